// File: doc/BRIEF.md
# Platform Interrupt Claim Controller

This block collects level-sensitive interrupt requests from up to 31 sources and presents them to a small number of targets. Each target is one hart in one privilege mode and is called a context here. Each source has a programmable urgency level. Each context has its own mask of the sources it accepts and its own urgency threshold. A context's interrupt line rises when an accepted, pending source is more urgent than that context's threshold.

Software in a context reads the context's claim/complete word to learn which source to service. That read hands the source to the reader. The source's pending flag drops, and no context can see the source again until software writes the same source number back to a claim/complete word. A claim read can also serve as a poll for the most urgent waiting source.

Registers sit behind a word-addressed request port that never stalls. Read data comes back one cycle after the request. The address map uses six bits:

- words 1..31 hold the source levels;
- words 32 + c hold the context masks;
- words 40 + c hold the thresholds;
- words 48 + c are the claim/complete words;
- word 56 shows the pending vector.

Top module: `pic_top`

## Requirements
- R1: After reset, all levels, masks and thresholds read 0, the pending vector reads 0, every interrupt line is low and every claim read returns 0.
- R2: A source whose level is 0 is never returned by a claim and never raises an interrupt line, although its pending bit may be set.
- R3: A claim read for context c returns the source number with the greatest level among sources that are pending, enabled in mask c and have a non-zero level. Equal levels resolve to the smaller source number. The threshold does not affect the claim result.
- R4: A claim read returns 0 when no source qualifies for that context.
- R5: A source whose bit (bit k for source k) is clear in context c's mask is never returned to context c.
- R6: A successful claim clears the source's pending bit and puts the source in service. While it is in service, the source is offered to no context, even if its input stays high.
- R7: A write of an in-service source number to a claim/complete word ends service. If the input is still high, the pending bit is set again on the following clock edge.
- R8: A completion write whose value is not a source currently in service changes no pending or service state.
- R9: Interrupt line c is high exactly when some pending source enabled in mask c has a level strictly greater than threshold c.
- R10: A read request returns its data with rsp_valid one cycle later. The level and threshold registers keep only their low 3 bits, and mask bit 0 reads 0.
- R11: Word 56 returns the pending vector, with source k at bit k and bit 0 always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | 31 | Level request per source, bit k = source k |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Always 1; every request is taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq | output | 2 | Interrupt line per context |

## Verification
The assertions rely on three conditions. At most one register access arrives per cycle, so a claim and a completion never coincide. Source inputs are plain levels sampled on the clock. Control inputs carry no unknowns while req_valid is high. The stimulus keeps to these conditions: it drives every request and every source change on the falling edge, issues one access at a time, and holds req_valid low during reset. The sweeps program every source level and two different masks. They then claim until the claim read returns nothing, re-arm sources by completing them, and finally leave only level-0 sources pending.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Upper three word-address bits select a register region.
  typedef enum logic [2:0] {
    RGN_LVL_A  = 3'd0,
    RGN_LVL_B  = 3'd1,
    RGN_LVL_C  = 3'd2,
    RGN_LVL_D  = 3'd3,
    RGN_MASK   = 3'd4,
    RGN_THRESH = 3'd5,
    RGN_CLAIM  = 3'd6,
    RGN_STATUS = 3'd7
  } rgn_e;
endpackage

// File: rtl/pic_gateway.sv
module pic_gateway #(
  parameter int NSRC = 31
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [NSRC:1]   src,
  input  logic [NSRC:1]   claim,
  input  logic [NSRC:1]   complete,
  output logic [NSRC:1]   pend,
  output logic [NSRC:1]   busy
);
  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    logic pend_d, pend_q, busy_d, busy_q;

    always_comb begin
      pend_d = pend_q | (src[s] & ~busy_q);
      busy_d = busy_q;
      if (claim[s]) begin
        pend_d = 1'b0;
        busy_d = 1'b1;
      end else if (complete[s]) begin
        busy_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        busy_q <= 1'b0;
      end else begin
        pend_q <= pend_d;
        busy_q <= busy_d;
      end
    end

    assign pend[s] = pend_q;
    assign busy[s] = busy_q;

    AST_BUSY_EXCL_PEND: assert property (@(posedge clk) disable iff (!rst_ni)
      busy_q |-> !pend_q) else $error("busy source also pending"); // R6
    AST_CLAIM_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_ni)
      claim[s] |-> pend_q) else $error("claim of non-pending source"); // R3
    AST_CLAIM_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_ni)
      claim[s] |=> (busy_q && !pend_q)) else $error("claim did not withdraw"); // R6
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [NSRC*PRIO_W-1:0] lvl_flat,
  input  logic [NSRC:1]          cand,
  input  logic [PRIO_W-1:0]      thr,
  output logic [ID_W-1:0]        best_id,
  output logic                   irq
);
  logic [PRIO_W-1:0] best_lvl;

  // Strict compare: lowest id wins ties, level 0 never wins.
  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (cand[s] && (lvl_flat[(s-1)*PRIO_W +: PRIO_W] > best_lvl)) begin
        best_lvl = lvl_flat[(s-1)*PRIO_W +: PRIO_W];
        best_id  = ID_W'(s);
      end
    end
  end

  assign irq = (best_lvl > thr);
endmodule

// File: rtl/pic_top.sv
module pic_top #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int NCTX   = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_in,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [5:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NCTX-1:0]   irq
);
  import pic_pkg::*;

  localparam int ID_W = $clog2(NSRC + 1);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Decode
  rgn_e       rgn;
  logic [2:0] sub;
  logic       rd_req, wr_req, ctx_hit, claim_rd, cmpl_wr;
  assign rgn       = rgn_e'(req_addr[5:3]);
  assign sub       = req_addr[2:0];
  assign rd_req    = req_valid && !req_write;
  assign wr_req    = req_valid && req_write;
  assign ctx_hit   = (int'(sub) < NCTX);
  assign claim_rd  = rd_req && (rgn == RGN_CLAIM) && ctx_hit;
  assign cmpl_wr   = wr_req && (rgn == RGN_CLAIM) && ctx_hit;
  assign req_ready = 1'b1;

  // Source levels
  logic [NSRC*PRIO_W-1:0] lvl_flat;
  for (genvar s = 1; s <= NSRC; s++) begin : g_lvl
    logic              lvl_we;
    logic [PRIO_W-1:0] lvl_q;
    assign lvl_we = wr_req && !req_addr[5] && (req_addr[4:0] == 5'(s));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)     lvl_q <= '0;
      else if (lvl_we) lvl_q <= req_wdata[PRIO_W-1:0];
    end
    assign lvl_flat[(s-1)*PRIO_W +: PRIO_W] = lvl_q;
  end

  // Gateways
  logic [NSRC:1] pend, busy, claim_vec, cmpl_vec;
  pic_gateway #(.NSRC(NSRC)) gw_i (
    .clk(clk), .rst_ni(rst_ni), .src(src_in),
    .claim(claim_vec), .complete(cmpl_vec), .pend(pend), .busy(busy)
  );

  // Per-context mask, threshold and arbiter
  logic [NCTX-1:0][NSRC:1]     mask_all;
  logic [NCTX-1:0][PRIO_W-1:0] thr_all;
  logic [NCTX-1:0][ID_W-1:0]   best_all;
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic              mask_we, thr_we;
    logic [NSRC:1]     mask_q;
    logic [PRIO_W-1:0] thr_q;
    assign mask_we = wr_req && (rgn == RGN_MASK)   && (int'(sub) == c);
    assign thr_we  = wr_req && (rgn == RGN_THRESH) && (int'(sub) == c);
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q <= '0;
        thr_q  <= '0;
      end else begin
        if (mask_we) mask_q <= req_wdata[NSRC:1];
        if (thr_we)  thr_q  <= req_wdata[PRIO_W-1:0];
      end
    end
    assign mask_all[c] = mask_q;
    assign thr_all[c]  = thr_q;

    pic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) arb_i (
      .lvl_flat(lvl_flat), .cand(pend & mask_q), .thr(thr_q),
      .best_id(best_all[c]), .irq(irq[c])
    );

    AST_IRQ_HAS_CAND: assert property (@(posedge clk) disable iff (!rst_ni)
      irq[c] |-> |(pend & mask_q)) else $error("irq without candidate"); // R9
  end

  // Claim and completion
  logic [ID_W-1:0] claim_id;
  always_comb begin
    claim_id = '0;
    for (int c = 0; c < NCTX; c++)
      if (int'(sub) == c) claim_id = best_all[c];
  end

  always_comb begin
    for (int s = 1; s <= NSRC; s++) begin
      claim_vec[s] = claim_rd && (claim_id == ID_W'(s));
      cmpl_vec[s]  = cmpl_wr && (req_wdata == DATA_W'(s)) && busy[s];
    end
  end

  // Read path
  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (rgn)
      RGN_LVL_A, RGN_LVL_B, RGN_LVL_C, RGN_LVL_D: begin
        for (int s = 1; s <= NSRC; s++)
          if (req_addr[4:0] == 5'(s)) rd_next[PRIO_W-1:0] = lvl_flat[(s-1)*PRIO_W +: PRIO_W];
      end
      RGN_MASK: begin
        for (int c = 0; c < NCTX; c++)
          if (int'(sub) == c) rd_next[NSRC:1] = mask_all[c];
      end
      RGN_THRESH: begin
        for (int c = 0; c < NCTX; c++)
          if (int'(sub) == c) rd_next[PRIO_W-1:0] = thr_all[c];
      end
      RGN_CLAIM:  if (ctx_hit) rd_next[ID_W-1:0] = claim_id;
      RGN_STATUS: if (sub == 3'd0) rd_next[NSRC:1] = pend;
      default:    rd_next = '0;
    endcase
  end

  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_req;
      if (rd_req) rsp_rdata_q <= rd_next;
    end
  end
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(claim_vec)) else $error("more than one source claimed"); // R3
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid_q |-> $past(rd_req)) else $error("response without read"); // R10
endmodule

// File: tb/pic_top_tb.sv
`timescale 1ns/1ps
module pic_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:1] src_in;
  logic        req_valid, req_ready, req_write, rsp_valid;
  logic [5:0]  req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic [1:0]  irq;

  always #10 clk = ~clk;

  pic_top dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  int errors = 0;
  int checks = 0;

  // Model state built from the requirements
  int          lvl_m [32];
  logic [31:0] mask_m [2];
  int          thr_m [2];
  logic [31:0] pend_m, busy_m, srcv_m;

  function automatic int best_lvl(int c);
    int bl = 0;
    for (int s = 1; s < 32; s++)
      if (pend_m[s] && mask_m[c][s] && lvl_m[s] > bl) bl = lvl_m[s];
    return bl;
  endfunction

  function automatic int best_id(int c);
    int bl = 0; int bi = 0;
    for (int s = 1; s < 32; s++)
      if (pend_m[s] && mask_m[c][s] && lvl_m[s] > bl) begin bl = lvl_m[s]; bi = s; end
    return bi;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int cl, int cp);
    logic [31:0] np;
    srcv_m = {src_in, 1'b0};
    np = pend_m | (srcv_m & ~busy_m);
    if (cl != 0) begin np[cl] = 1'b0; busy_m[cl] = 1'b1; end
    if (cp != 0) busy_m[cp] = 1'b0;
    pend_m = np;
  endtask

  task automatic tick();
    @(posedge clk); step(0, 0); @(negedge clk);
  endtask

  task automatic op(bit wr, int addr, logic [31:0] data, output logic [31:0] rd);
    int cl = 0; int cp = 0;
    if (!wr && addr >= 48 && addr < 50) cl = best_id(addr - 48);
    if (wr && addr >= 48 && addr < 50 && data >= 1 && data <= 31)
      if (busy_m[data[4:0]]) cp = int'(data);
    req_valid = 1'b1; req_write = wr; req_addr = 6'(addr); req_wdata = data;
    @(posedge clk);
    if (wr) begin
      if (addr >= 1 && addr < 32) lvl_m[addr] = int'(data & 32'h7);
      if (addr == 32 || addr == 33) mask_m[addr-32] = data & 32'hFFFF_FFFE;
      if (addr == 40 || addr == 41) thr_m[addr-40] = int'(data & 32'h7);
    end
    step(cl, cp);
    @(negedge clk);
    rd = rsp_rdata;
    chk("R10 rsp_valid", {31'd0, rsp_valid}, {31'd0, !wr});
    req_valid = 1'b0;
  endtask

  task automatic chk_irq(string tag);
    for (int c = 0; c < 2; c++)
      chk(tag, {31'd0, irq[c]}, {31'd0, best_lvl(c) > thr_m[c]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd, exp;
    int id;
    for (int s = 0; s < 32; s++) lvl_m[s] = 0;
    mask_m[0] = 0; mask_m[1] = 0; thr_m[0] = 0; thr_m[1] = 0;
    pend_m = 0; busy_m = 0; srcv_m = 0;
    rst_n = 1'b0; src_in = '0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {30'd0, irq}, 32'd0);
    op(0, 56, 0, rd); chk("R1 pending", rd, 0);
    op(0, 48, 0, rd); chk("R1 claim", rd, 0);
    op(0, 5, 0, rd);  chk("R1 level", rd, 0);
    op(0, 41, 0, rd); chk("R1 threshold", rd, 0);
    op(0, 33, 0, rd); chk("R1 mask", rd, 0);

    // R10 level sweep with readback, plus width masking
    for (int s = 1; s < 32; s++) op(1, s, 32'((s * 3) % 8), rd);
    for (int s = 1; s < 32; s++) begin
      op(0, s, 0, rd); chk("R10 level readback", rd, 32'(lvl_m[s]));
    end
    op(1, 1, 32'hF, rd); op(0, 1, 0, rd); chk("R10 level width", rd, 32'h7);
    op(1, 1, 32'd3, rd);
    op(1, 32, 32'hFFFF_FFFF, rd); op(1, 33, 32'hAAAA_AAAB, rd);
    op(0, 32, 0, rd); chk("R10 mask0 bit0", rd, 32'hFFFF_FFFE);
    op(0, 33, 0, rd); chk("R10 mask1", rd, 32'hAAAA_AAAA);

    // All sources raised
    src_in = '1;
    tick();
    op(0, 56, 0, rd); chk("R11 pending all", rd, 32'hFFFF_FFFE);
    chk_irq("R9 irq all raised");

    // R9 threshold sweep on context 1
    for (int t = 0; t < 8; t++) begin
      op(1, 41, 32'(t), rd);
      chk("R9 threshold sweep", {31'd0, irq[1]}, {31'd0, best_lvl(1) > t});
    end
    op(1, 41, 0, rd);

    // R5 context 1 claims, odd sources only
    for (int k = 0; k < 3; k++) begin
      exp = 32'(best_id(1));
      op(0, 49, 0, rd); chk("R5 claim ctx1", rd, exp);
      chk("R5 odd source", {31'd0, rd[0]}, 32'd1);
    end

    // R3 / R2 / R6 context 0 drains everything
    for (int k = 0; k < 40; k++) begin
      exp = 32'(best_id(0));
      op(0, 48, 0, rd); chk("R3 claim ctx0", rd, exp);
      if (rd != 0) chk("R2 claimed level nonzero", {31'd0, lvl_m[rd[4:0]] == 0}, 32'd0);
      chk_irq("R9 irq during drain");
      if (rd == 0) break;
    end
    chk("R4 claim empty", rd, 32'd0);
    op(0, 49, 0, rd); chk("R6 ctx1 sees none", rd, 32'd0);
    exp = pend_m;
    op(0, 56, 0, rd); chk("R6 pending withdrawn", rd, exp);
    chk("R6 only level-0 left", rd, 32'h0101_0100);

    // R8 bogus completions
    op(1, 48, 32'd8, rd); op(1, 48, 32'd0, rd); op(1, 49, 32'd40, rd);
    tick();
    op(0, 56, 0, rd); chk("R8 bogus complete ignored", rd, 32'h0101_0100);
    op(0, 48, 0, rd); chk("R8 still nothing claimable", rd, 32'd0);

    // R7 completions re-arm with input high
    for (int s = 1; s < 32; s++)
      if (busy_m[s]) op(1, 49, 32'(s), rd);
    tick();
    exp = pend_m;
    op(0, 56, 0, rd); chk("R7 re-armed pending", rd, exp);
    chk("R7 all pending again", rd, 32'hFFFF_FFFE);
    exp = 32'(best_id(0));
    op(0, 48, 0, rd); chk("R7 claim after re-arm", rd, exp);

    // Inputs low: drain, complete, nothing re-arms
    src_in = '0;
    for (int k = 0; k < 40; k++) begin
      exp = 32'(best_id(0));
      op(0, 48, 0, rd); chk("R3 second drain", rd, exp);
      if (rd == 0) break;
    end
    for (int s = 1; s < 32; s++)
      if (busy_m[s]) op(1, 48, 32'(s), rd);
    tick(); tick();
    op(0, 56, 0, rd); chk("R2 level-0 pending remain", rd, 32'h0101_0100);
    chk("R2 irq low", {30'd0, irq}, 32'd0);
    op(0, 48, 0, rd); chk("R2 claim ctx0 none", rd, 32'd0);
    op(0, 49, 0, rd); chk("R4 claim ctx1 none", rd, 32'd0);

    // R9 strict threshold: single source at level 4
    src_in[5] = 1'b1;
    op(1, 5, 32'd4, rd);
    op(1, 40, 32'd4, rd);
    chk("R9 equal level no irq", {31'd0, irq[0]}, 32'd0);
    op(1, 40, 32'd3, rd);
    chk("R9 above threshold irq", {31'd0, irq[0]}, 32'd1);
    chk("R5 ctx1 masked", {31'd0, irq[1]}, {31'd0, best_lvl(1) > thr_m[1]});
    op(0, 48, 0, rd); chk("R3 claim single", rd, 32'd5);
    chk("R6 irq drops after claim", {31'd0, irq[0]}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule